// File: doc/BRIEF.md
# Priority Round-Robin Output Port

This block is one output direction of an on-chip network router. Up to five input ports can have a flit waiting for this direction on each of two service levels. The urgent level carries signalling traffic. The bulk level carries read/write traffic. Every clock the block picks at most one flit, strobes a read back to the input that holds it, and presents the flit on a registered output to the next router or local unit. The flit appears one cycle after the read strobe.

On each level a round-robin arbiter chooses the input that is served. Once an input starts a multi-flit (wormhole) packet on a level, that level stays with the input until the packet's last flit leaves. The urgent level preempts the bulk level one flit at a time, and the interrupted bulk packet continues from the same input afterwards. Each level has its own credit counter that tracks free slots in the downstream buffer. The counter stops that level when it reaches zero, and a returned credit can be spent on the next cycle.

Top module: `prio_rr_outport`

## Requirements
- R1: After reset, `out_valid` is 0, `out_flit` is all zeros, no read strobe is raised while nothing requests, and each level holds 4 credits.
- R2: At most one read strobe across both levels is high in any cycle. The flit at the strobed input appears on `out_flit` in the next cycle with `out_valid`=1, and `out_level` is 0 for urgent and 1 for bulk.
- R3: Single-flit packets competing on one level are served in rotation. The search starts at the input after the last input whose packet completed, and starts at input 0 after reset.
- R4: The packet kind sits in flit bits [15:14]: 00 idle, 01 body, 10 end of packet, 11 single-flit packet. On a level, once a body flit is granted, only that input is granted on that level until its end-of-packet flit is granted.
- R5: Whenever an urgent flit can be sent, no bulk flit is sent in that cycle. An interrupted bulk packet resumes from the same input when urgent traffic stops.
- R6: A level whose credit count is zero raises no read strobe. Each sent flit costs one credit of its level, and the levels are independent.
- R7: A credit returned in cycle t is not spendable in cycle t, and is spendable from cycle t+1.
- R8: When eligible flits keep arriving, one flit is sent per cycle, with no idle cycle between inputs or between levels.
- R9: In a cycle with no send, the following cycle shows `out_valid`=0 and `out_flit`=0.
- R10: While a packet is open on a level and its owner has no flit waiting, no other input of that level is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_sig | input | 5 | Urgent-level flit waiting, one bit per input |
| flits_sig | input | 80 | Urgent-level head flits, input i at bits [16i+15:16i] |
| req_rw | input | 5 | Bulk-level flit waiting, one bit per input |
| flits_rw | input | 80 | Bulk-level head flits, same packing |
| credit_ret_sig | input | 1 | One urgent-level downstream slot freed |
| credit_ret_rw | input | 1 | One bulk-level downstream slot freed |
| pop_sig | output | 5 | Urgent-level read strobe to input i |
| pop_rw | output | 5 | Bulk-level read strobe to input i |
| out_flit | output | 16 | Flit to the next hop |
| out_valid | output | 1 | `out_flit` carries a flit |
| out_level | output | 1 | Level of `out_flit`: 0 urgent, 1 bulk |

## Verification
A stuck lock or a wrong owner shows up as a read strobe on another input of the same level, either in the same cycle or as a dead cycle while other inputs wait. A drifting rotation pointer shows up as a grant order that differs from the expected order on the second contended flit. A credit counter that is off by one lets a fifth flit out, or holds back the first flit after a return, and this is visible within a cycle of the credit event. A broken output register shows up one cycle after the strobe, as a mismatch in the flit, the level, or the idle zeros.

// File: rtl/noc_op_pkg.sv
package noc_op_pkg;
  localparam int MAX_IN = 8;
  localparam int PICK_W = 3;

  typedef enum logic [1:0] {
    K_IDLE   = 2'b00,
    K_BODY   = 2'b01,
    K_END    = 2'b10,
    K_SINGLE = 2'b11
  } flit_kind_e;

  // {found, index}: first requester at or after ptr, wrapping at n
  function automatic logic [PICK_W:0] rr_pick(input logic [MAX_IN-1:0] req,
                                             input logic [PICK_W-1:0] ptr,
                                             input int n);
    logic [PICK_W:0] r;
    int idx;
    r = '0;
    for (int k = 0; k < MAX_IN; k++) begin
      if (k < n && !r[PICK_W]) begin
        idx = (int'(ptr) + k) % n;
        if (req[idx]) r = {1'b1, PICK_W'(idx)};
      end
    end
    return r;
  endfunction

  function automatic int next_ptr(input int idx, input int n);
    return (idx + 1) % n;
  endfunction

  function automatic logic is_tail(input logic [1:0] kind);
    return (kind == K_END) || (kind == K_SINGLE);
  endfunction

  function automatic int credit_next(input int cnt, input logic send, input logic ret);
    return cnt - int'(send) + int'(ret);
  endfunction
endpackage

// File: rtl/op_credit.sv
module op_credit
  import noc_op_pkg::*;
#(
  parameter int CREDIT_MAX = 4,
  localparam int CNT_W = $clog2(CREDIT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             send,
  input  logic             ret,
  output logic             avail,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n) count <= CNT_W'(CREDIT_MAX);
    else        count <= CNT_W'(credit_next(int'(count), send, ret));
  end

  assign avail = (count != '0);
endmodule

// File: rtl/op_lane.sv
module op_lane
  import noc_op_pkg::*;
#(
  parameter int NUM_IN = 5,
  parameter int FLIT_W = 16,
  localparam int IDX_W = $clog2(NUM_IN)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_IN-1:0]        req,
  input  logic [NUM_IN*FLIT_W-1:0] flits,
  input  logic                     may_send,
  output logic                     cand_ok,
  output logic                     fire,
  output logic [NUM_IN-1:0]        pop,
  output logic [FLIT_W-1:0]        sel_flit,
  output logic                     locked,
  output logic [IDX_W-1:0]         owner
);
  logic [IDX_W-1:0]  ptr;
  logic [IDX_W-1:0]  cand_idx;
  logic [PICK_W:0]   pick;

  always_comb begin
    pick = rr_pick(MAX_IN'(req), PICK_W'(ptr), NUM_IN);
    if (locked) begin
      cand_ok  = req[owner];
      cand_idx = owner;
    end else begin
      cand_ok  = pick[PICK_W];
      cand_idx = IDX_W'(pick[PICK_W-1:0]);
    end
    fire     = cand_ok && may_send;
    sel_flit = flits[int'(cand_idx)*FLIT_W +: FLIT_W];
    pop      = fire ? (NUM_IN'(1) << cand_idx) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      owner  <= '0;
      ptr    <= '0;
    end else if (fire) begin
      if (is_tail(sel_flit[FLIT_W-1 -: 2])) begin
        locked <= 1'b0;
        ptr    <= IDX_W'(next_ptr(int'(cand_idx), NUM_IN));
      end else begin
        locked <= 1'b1;
        owner  <= cand_idx;
      end
    end
  end
endmodule

// File: rtl/prio_rr_outport.sv
module prio_rr_outport
  import noc_op_pkg::*;
#(
  parameter int NUM_IN     = 5,
  parameter int FLIT_W     = 16,
  parameter int CREDIT_MAX = 4,
  localparam int IDX_W = $clog2(NUM_IN),
  localparam int CNT_W = $clog2(CREDIT_MAX + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_IN-1:0]        req_sig,
  input  logic [NUM_IN*FLIT_W-1:0] flits_sig,
  input  logic [NUM_IN-1:0]        req_rw,
  input  logic [NUM_IN*FLIT_W-1:0] flits_rw,
  input  logic                     credit_ret_sig,
  input  logic                     credit_ret_rw,
  output logic [NUM_IN-1:0]        pop_sig,
  output logic [NUM_IN-1:0]        pop_rw,
  output logic [FLIT_W-1:0]        out_flit,
  output logic                     out_valid,
  output logic                     out_level
);
  // level 0 = urgent (signalling), level 1 = bulk (read/write)
  logic [1:0][NUM_IN-1:0]        req_l;
  logic [1:0][NUM_IN*FLIT_W-1:0] flits_l;
  logic [1:0]                    ret_l;
  logic [1:0]                    credit_ok;
  logic [1:0][CNT_W-1:0]         credit_cnt;
  logic [1:0]                    may_send;
  logic [1:0]                    cand_ok;
  logic [1:0]                    fire;
  logic [1:0][NUM_IN-1:0]        pop_l;
  logic [1:0][FLIT_W-1:0]        sel_l;
  logic [1:0]                    lane_locked;
  logic [1:0][IDX_W-1:0]         lane_owner;

  assign req_l   = {req_rw, req_sig};
  assign flits_l = {flits_rw, flits_sig};
  assign ret_l   = {credit_ret_rw, credit_ret_sig};

  // urgent level sends on credit alone; bulk yields whenever urgent fires
  assign may_send[0] = credit_ok[0];
  assign may_send[1] = credit_ok[1] && !fire[0];

  for (genvar l = 0; l < 2; l++) begin : g_level
    op_credit #(.CREDIT_MAX(CREDIT_MAX)) i_credit (
      .clk  (clk),
      .rst_n(rst_n),
      .send (fire[l]),
      .ret  (ret_l[l]),
      .avail(credit_ok[l]),
      .count(credit_cnt[l])
    );

    op_lane #(.NUM_IN(NUM_IN), .FLIT_W(FLIT_W)) i_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req_l[l]),
      .flits   (flits_l[l]),
      .may_send(may_send[l]),
      .cand_ok (cand_ok[l]),
      .fire    (fire[l]),
      .pop     (pop_l[l]),
      .sel_flit(sel_l[l]),
      .locked  (lane_locked[l]),
      .owner   (lane_owner[l])
    );
  end

  assign pop_sig = pop_l[0];
  assign pop_rw  = pop_l[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_level <= 1'b0;
      out_flit  <= '0;
    end else begin
      out_valid <= |fire;
      out_level <= fire[1];
      out_flit  <= fire[0] ? sel_l[0] : (fire[1] ? sel_l[1] : '0);
    end
  end
endmodule

// File: rtl/op_port_checker.sv
module op_port_checker #(
  parameter int NUM_IN     = 5,
  parameter int FLIT_W     = 16,
  parameter int CREDIT_MAX = 4,
  localparam int IDX_W = $clog2(NUM_IN),
  localparam int CNT_W = $clog2(CREDIT_MAX + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_IN-1:0] req_sig,
  input logic [NUM_IN-1:0] pop_sig,
  input logic [NUM_IN-1:0] pop_rw,
  input logic              credit_ret_sig,
  input logic [FLIT_W-1:0] out_flit,
  input logic              out_valid,
  input logic              out_level,
  input logic [CNT_W-1:0]  cnt_sig,
  input logic [CNT_W-1:0]  cnt_rw,
  input logic              locked_sig,
  input logic              locked_rw,
  input logic [IDX_W-1:0]  owner_rw
);
  a_r2_one_pop: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pop_rw, pop_sig}));

  a_r2_pop_then_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (|{pop_rw, pop_sig}) |=> out_valid);

  a_r2_bulk_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (|pop_rw) |=> out_level);

  a_r2_urgent_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (|pop_sig) |=> !out_level);

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_flit == '0));

  a_r6_sig_no_credit: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_sig == '0) |-> (pop_sig == '0));

  a_r6_rw_no_credit: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rw == '0) |-> (pop_rw == '0));

  a_r6_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt_sig) <= CREDIT_MAX) && (int'(cnt_rw) <= CREDIT_MAX));

  a_r7_credit_ret: assert property (@(posedge clk) disable iff (!rst_n)
    (credit_ret_sig && (pop_sig == '0)) |=> (cnt_sig == $past(cnt_sig) + 1'b1));

  a_r5_urgent_first: assert property (@(posedge clk) disable iff (!rst_n)
    ((|req_sig) && (cnt_sig != '0) && !locked_sig) |-> (pop_rw == '0));

  a_r10_lock_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_rw && (|pop_rw)) |-> pop_rw[owner_rw]);
endmodule

bind prio_rr_outport op_port_checker #(
  .NUM_IN(NUM_IN), .FLIT_W(FLIT_W), .CREDIT_MAX(CREDIT_MAX)
) i_op_port_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_sig       (req_sig),
  .pop_sig       (pop_sig),
  .pop_rw        (pop_rw),
  .credit_ret_sig(credit_ret_sig),
  .out_flit      (out_flit),
  .out_valid     (out_valid),
  .out_level     (out_level),
  .cnt_sig       (credit_cnt[0]),
  .cnt_rw        (credit_cnt[1]),
  .locked_sig    (lane_locked[0]),
  .locked_rw     (lane_locked[1]),
  .owner_rw      (lane_owner[1])
);

// File: tb/test_prio_rr_outport.sv
module test_prio_rr_outport;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  req_sig = '0, req_rw = '0;
  logic [79:0] flits_sig = '0, flits_rw = '0;
  logic        credit_ret_sig = 1'b0, credit_ret_rw = 1'b0;
  logic [4:0]  pop_sig, pop_rw;
  logic [15:0] out_flit;
  logic        out_valid, out_level;

  prio_rr_outport i_prio_rr_outport (.*);

  always #10 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench traffic model: per level, per input
  int left [2][5];
  int plen [2][5];
  int pos  [2][5];
  int seq  [2][5];
  bit hold [2][5];
  bit auto_ret = 1'b1;
  bit force_ret_sig = 1'b0;
  int last_lvl = -1;
  int g_code;
  bit exp_v = 1'b0;
  bit exp_l = 1'b0;
  logic [15:0] exp_f = '0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] make_flit(input int l, input int i);
    logic [1:0] k;
    if (plen[l][i] == 1)                  k = 2'b11;
    else if (pos[l][i] == plen[l][i] - 1) k = 2'b10;
    else                                  k = 2'b01;
    return {k, 1'(l), 3'(i), 10'(seq[l][i])};
  endfunction

  task automatic drive();
    for (int i = 0; i < 5; i++) begin
      req_sig[i] = (left[0][i] > 0) && !hold[0][i];
      req_rw[i]  = (left[1][i] > 0) && !hold[1][i];
      flits_sig[i*16 +: 16] = make_flit(0, i);
      flits_rw[i*16 +: 16]  = make_flit(1, i);
    end
    credit_ret_sig = (auto_ret && last_lvl == 0) || force_ret_sig;
    credit_ret_rw  = auto_ret && last_lvl == 1;
  endtask

  // one clock: drive at negedge, read strobes, check registered output next negedge
  task automatic tick();
    logic [4:0] ps, pr;
    int l, idx;
    drive();
    #1;
    ps = pop_sig; pr = pop_rw;
    l = -1; idx = -1;
    if ($countones({pr, ps}) > 1) chk(0, "R2 one strobe", $countones({pr, ps}), 1);
    for (int i = 0; i < 5; i++) begin
      if (ps[i]) begin l = 0; idx = i; end
      else if (pr[i]) begin l = 1; idx = i; end
    end
    g_code = (l < 0) ? -1 : l * 8 + idx;
    @(posedge clk);
    @(negedge clk);
    if (l >= 0) begin
      exp_v = 1'b1; exp_l = 1'(l); exp_f = make_flit(l, idx);
      left[l][idx]--; seq[l][idx]++;
      pos[l][idx] = (pos[l][idx] + 1) % plen[l][idx];
    end else begin
      exp_v = 1'b0; exp_l = 1'b0; exp_f = '0;
    end
    last_lvl = l;
    chk(out_valid == exp_v, "R2/R9 out_valid", int'(out_valid), int'(exp_v));
    chk(out_flit == exp_f, "R2/R9 out_flit", int'(out_flit), int'(exp_f));
    if (exp_v) chk(out_level == exp_l, "R2 out_level", int'(out_level), int'(exp_l));
  endtask

  task automatic step_expect(input int code, input string rq);
    tick();
    chk(g_code == code, rq, g_code, code);
  endtask

  task automatic do_reset();
    for (int l = 0; l < 2; l++)
      for (int i = 0; i < 5; i++) begin
        left[l][i] = 0; plen[l][i] = 1; pos[l][i] = 0; seq[l][i] = 0; hold[l][i] = 0;
      end
    auto_ret = 1'b1; force_ret_sig = 1'b0; last_lvl = -1;
    @(negedge clk); rst_n = 1'b0; drive();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(out_flit == '0, "R1 out_flit", int'(out_flit), 0);
    chk({pop_sig, pop_rw} == '0, "R1 strobes", int'({pop_sig, pop_rw}), 0);
    @(negedge clk);
    step_expect(-1, "R9 idle");
  endtask

  // R3 R8: single-flit rotation on the urgent level
  task automatic t_rotation();
    do_reset();
    left[0][0] = 2; left[0][2] = 2; left[0][4] = 2;
    step_expect(0, "R3 grant 1"); step_expect(2, "R3 grant 2");
    step_expect(4, "R3 grant 3"); step_expect(0, "R3 wrap");
    step_expect(2, "R8 grant 5"); step_expect(4, "R8 grant 6");
    step_expect(-1, "R9 drained");
  endtask

  // R4: wormhole lock on the bulk level
  task automatic t_wormhole();
    do_reset();
    plen[1][0] = 2; left[1][0] = 2;
    plen[1][1] = 3; left[1][1] = 3;
    plen[1][3] = 2; left[1][3] = 2;
    step_expect(8, "R4 pkt0 f0"); step_expect(8, "R4 pkt0 f1");
    step_expect(9, "R4 pkt1 f0"); step_expect(9, "R4 pkt1 f1");
    step_expect(9, "R4 pkt1 f2"); step_expect(11, "R4 pkt3 f0");
    step_expect(11, "R4 pkt3 f1"); step_expect(-1, "R9 drained");
  endtask

  // R5 R8: urgent preempts an open bulk packet, bulk resumes with same owner
  task automatic t_preempt();
    do_reset();
    plen[1][2] = 4; left[1][2] = 4;
    step_expect(10, "R5 bulk f0");
    plen[1][3] = 2; left[1][3] = 2;
    step_expect(10, "R5 bulk f1");
    left[0][1] = 2;
    step_expect(1, "R5 urgent 1"); step_expect(1, "R5 urgent 2");
    step_expect(10, "R5 resume f2"); step_expect(10, "R5 resume f3");
    step_expect(11, "R8 next owner"); step_expect(11, "R8 next owner f1");
  endtask

  // R6 R7: credit exhaustion, level independence, return timing
  task automatic t_credit();
    do_reset();
    auto_ret = 1'b0;
    left[0][0] = 6;
    for (int c = 0; c < 4; c++) step_expect(0, "R6 initial credit");
    left[1][1] = 1;
    step_expect(9, "R6 bulk independent");
    step_expect(-1, "R6 urgent stalled");
    force_ret_sig = 1'b1;
    step_expect(-1, "R7 not same cycle");
    force_ret_sig = 1'b0;
    step_expect(0, "R7 usable next cycle");
    step_expect(-1, "R6 stalled again");
  endtask

  // R10 R9: open packet bubble blocks other inputs of that level
  task automatic t_bubble();
    do_reset();
    plen[1][0] = 2; left[1][0] = 2; left[1][1] = 1;
    step_expect(8, "R10 owner f0");
    hold[1][0] = 1'b1;
    step_expect(-1, "R10 no other grant");
    hold[1][0] = 1'b0;
    step_expect(8, "R10 owner end");
    step_expect(9, "R10 after release");
  endtask

  initial begin
    t_reset();
    t_rotation();
    t_wormhole();
    t_preempt();
    t_credit();
    t_bubble();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule